// File: doc/BRIEF.md
# ADC Sample Buffer with Sticky Error Flags

This block sits between an analog-to-digital converter's result port and a processor's register interface. It holds up to four 12-bit conversion results and hands them back oldest first. The converter pushes a sample by raising `adc_valid` for one cycle. The processor can also inject a test sample by writing the data register (`cpu_wr_en`), and that sample follows exactly the same path. A read strobe (`cpu_rd_en`) removes the oldest sample. The removed value appears on `rd_data` in the cycle after the strobe and stays there until the next successful read.

Neither data edge has back-pressure. A converter cannot stall, so the block has no `ready` signal. Instead, a push that finds the buffer full is dropped and recorded in a sticky `overflow` flag. A read that finds the buffer empty is recorded in a sticky `underflow` flag. While either flag is set, the matching pointer is frozen. Only `flush` clears the two flags, and it also discards the stored samples. Level flags (`empty`, `almost_full`, `full`) are decoded from the stored count and follow it in the same cycle as the count register.

Top module: `adc_sample_fifo`

## Requirements
- R1: `full` is 1 exactly when DEPTH (default 4) samples are stored.
- R2: `almost_full` is 1 only when exactly DEPTH-1 samples are stored; it is 0 with fewer and also 0 when full.
- R3: `empty` is 1 exactly when no sample is stored.
- R4: A push that sees a full buffer, or a set `overflow`, is dropped and sets `overflow`. `overflow` stays 1 until a flush, and no push is stored while it is 1.
- R5: A read that sees an empty buffer, or a set `underflow`, sets `underflow` and leaves `rd_data` unchanged. `underflow` stays 1 until a flush, and no sample is removed while it is 1.
- R6: A successful read removes the oldest stored sample, and that sample appears on `rd_data` one cycle after the strobe.
- R7: A flush empties the buffer and clears `overflow` and `underflow` in the following cycle. Any push or read in the same cycle is ignored, and `rd_data` keeps its value.
- R8: A CPU data write with `adc_valid` low stores `cpu_wr_data` exactly as a converter push would.
- R9: When `adc_valid` and `cpu_wr_en` are both 1 in one cycle, only `adc_data` is pushed and the CPU value is discarded.
- R10: A push and a successful read in the same cycle, on a buffer that is neither empty nor full and has no sticky flag set, leave the level flags unchanged and raise no sticky flag.
- R11: After reset the buffer is empty, both sticky flags are 0 and `rd_data` is 0, so an underflow right after reset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard contents and clear sticky flags |
| adc_valid | input | 1 | Converter push strobe |
| adc_data | input | DATA_W | Converter sample |
| cpu_wr_en | input | 1 | Processor dummy-sample write strobe |
| cpu_wr_data | input | DATA_W | Processor dummy sample |
| cpu_rd_en | input | 1 | Processor read strobe |
| rd_data | output | DATA_W | Most recently read sample |
| empty | output | 1 | No sample stored |
| almost_full | output | 1 | Exactly DEPTH-1 samples stored |
| full | output | 1 | DEPTH samples stored |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a read found nothing |

## Verification
The bench builds the block with its defaults, DEPTH 4 and DATA_W 12. With only four slots, a few pushes reach the full boundary, pointer wrap-around and the overflow freeze. Random traffic therefore keeps crossing the almost-full and full levels and landing in both sticky states. A 12-bit data path lets every sample carry a distinct value, so reordering, a dropped sample or a stale read shows up directly on `rd_data`.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  typedef struct packed {
    logic empty;
    logic almost_full;
    logic full;
    logic overflow;
    logic underflow;
  } fifo_flags_t;
endpackage

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl
  import adc_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output fifo_flags_t      flags
);
  logic [CNT_W-1:0] count;
  logic             ovf_q, udf_q;
  logic             is_empty, is_full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_empty = (count == '0);
  assign is_full  = (count == CNT_W'(DEPTH));

  // Acceptance uses the state at the start of the cycle.
  assign wr_ok = push & ~is_full & ~ovf_q & ~flush;
  assign rd_ok = pop & ~is_empty & ~udf_q & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      if (wr_ok) wptr <= bump(wptr);
      if (rd_ok) rptr <= bump(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && (is_full || ovf_q)) ovf_q <= 1'b1;
      if (pop && (is_empty || udf_q)) udf_q <= 1'b1;
    end
  end

  always_comb begin
    flags.empty       = is_empty;
    flags.full        = is_full;
    flags.almost_full = (count == CNT_W'(DEPTH - 1)) && !is_full;
    flags.overflow    = ovf_q;
    flags.underflow   = udf_q;
  end
endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_ok,
  input  logic [PTR_W-1:0]  rptr,
  output logic [DATA_W-1:0] last_rd
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_ok && (wptr == PTR_W'(i))) slot[i] <= wdata;
    end
  end

  // Holds the last sample handed out; repeated on underflowing reads.
  always_ff @(posedge clk) begin
    if (!rst_n)     last_rd <= '0;
    else if (rd_ok) last_rd <= slot[rptr];
  end
endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
  import adc_fifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              adc_valid,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_full,
  output logic              full,
  output logic              overflow,
  output logic              underflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              push, wr_ok, rd_ok;
  logic [DATA_W-1:0] push_data;
  logic [PTR_W-1:0]  wptr, rptr;
  fifo_flags_t       flags;

  // Converter wins a same-cycle collision with a processor write.
  assign push      = adc_valid | cpu_wr_en;
  assign push_data = adc_valid ? adc_data : cpu_wr_data;

  adc_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (cpu_rd_en),
    .wr_ok (wr_ok),
    .rd_ok (rd_ok),
    .wptr  (wptr),
    .rptr  (rptr),
    .flags (flags)
  );

  adc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (wr_ok),
    .wptr    (wptr),
    .wdata   (push_data),
    .rd_ok   (rd_ok),
    .rptr    (rptr),
    .last_rd (rd_data)
  );

  assign empty       = flags.empty;
  assign almost_full = flags.almost_full;
  assign full        = flags.full;
  assign overflow    = flags.overflow;
  assign underflow   = flags.underflow;
endmodule

// File: rtl/adc_sample_fifo_chk.sv
module adc_sample_fifo_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              adc_valid,
  input logic              cpu_wr_en,
  input logic              cpu_rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty,
  input logic              almost_full,
  input logic              full,
  input logic              overflow,
  input logic              underflow
);
  logic any_push;
  assign any_push = adc_valid | cpu_wr_en;

  assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    full && !cpu_rd_en && !flush |=> full);

  assert_almost_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full |-> !full && !empty);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !flush |=> overflow);

  assert_udf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !flush |=> underflow);

  assert_udf_holds_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_en && (empty || underflow) |=> $stable(rd_data));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !overflow && !underflow);

  assert_flush_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(rd_data));

  assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_push && cpu_rd_en && !empty && !full && !overflow && !underflow && !flush
    |=> $stable({empty, almost_full, full}) && !overflow && !underflow);
endmodule

bind adc_sample_fifo adc_sample_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .adc_valid   (adc_valid),
  .cpu_wr_en   (cpu_wr_en),
  .cpu_rd_en   (cpu_rd_en),
  .rd_data     (rd_data),
  .empty       (empty),
  .almost_full (almost_full),
  .full        (full),
  .overflow    (overflow),
  .underflow   (underflow)
);

// File: tb/tb_adc_sample_fifo.sv
`timescale 1ns/1ps
module tb_adc_sample_fifo;
  localparam int DW = 12;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          adc_valid = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic          cpu_wr_en = 1'b0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic          cpu_rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          empty, almost_full, full, overflow, underflow;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R11 reset";

  // Reference model state
  int unsigned q[$];
  bit m_ovf = 0, m_udf = 0;
  int unsigned m_last = 0;

  always #10 clk = ~clk;

  adc_sample_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .adc_valid(adc_valid), .adc_data(adc_data),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_en(cpu_rd_en), .rd_data(rd_data),
    .empty(empty), .almost_full(almost_full), .full(full),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 empty", int'(empty), int'(q.size() == 0));
    chk("R2 almost_full", int'(almost_full), int'(q.size() == DEPTH - 1));
    chk("R1 full", int'(full), int'(q.size() == DEPTH));
    chk("R4 overflow", int'(overflow), int'(m_ovf));
    chk("R5 underflow", int'(underflow), int'(m_udf));
    chk("R6 rd_data", int'(rd_data), int'(m_last));
  endtask

  task automatic model_update();
    int n0;
    bit do_push;
    int unsigned d;
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_udf = 0; m_last = 0;
      return;
    end
    if (flush) begin
      q.delete(); m_ovf = 0; m_udf = 0;
      return;
    end
    n0 = q.size();
    do_push = adc_valid || cpu_wr_en;
    d = adc_valid ? adc_data : cpu_wr_data;   // R9: converter wins
    if (cpu_rd_en) begin
      if (n0 == 0 || m_udf) m_udf = 1;
      else m_last = q.pop_front();
    end
    if (do_push) begin
      if (n0 == DEPTH || m_ovf) m_ovf = 1;
      else q.push_back(d);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    flush = 0; adc_valid = 0; cpu_wr_en = 0; cpu_rd_en = 0;
  endtask

  task automatic adc_push(input int v);
    adc_valid = 1; adc_data = DW'(v); step();
  endtask

  task automatic cpu_push(input int v);
    cpu_wr_en = 1; cpu_wr_data = DW'(v); step();
  endtask

  task automatic rd();
    cpu_rd_en = 1; step();
  endtask

  task automatic do_flush();
    flush = 1; step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    phase = "R11 reset state";
    chk("R11 rd_data after reset", int'(rd_data), 0);

    phase = "R11 underflow after reset";
    rd(); step();
    chk("R11 underflow reads zero", int'(rd_data), 0);
    chk("R5 sticky underflow", int'(underflow), 1);
    adc_push(12'h111);                      // stored, but reads frozen
    rd();
    chk("R5 read frozen", int'(rd_data), 0);
    do_flush();

    phase = "R1 R2 R4 fill and overflow";
    for (int i = 0; i < DEPTH; i++) adc_push(12'h100 + i);
    chk("R1 full at depth", int'(full), 1);
    adc_push(12'hABC);
    chk("R4 overflow set", int'(overflow), 1);
    rd(); step();
    adc_push(12'hDEF);                      // still dropped: overflow frozen
    phase = "R6 drain oldest first";
    for (int i = 0; i < DEPTH; i++) rd();
    chk("R6 last drained", int'(rd_data), 12'h103);

    phase = "R7 flush with traffic";
    adc_valid = 1; adc_data = 12'h777; cpu_rd_en = 1; do_flush();
    chk("R7 flush clears overflow", int'(overflow), 0);
    chk("R7 rd_data kept", int'(rd_data), 12'h103);

    phase = "R8 cpu dummy writes";
    cpu_push(12'h055); cpu_push(12'h0AA);
    rd();
    chk("R8 cpu sample read", int'(rd_data), 12'h055);

    phase = "R9 adc beats cpu";
    adc_valid = 1; adc_data = 12'h321; cpu_wr_en = 1; cpu_wr_data = 12'h999; step();
    rd(); rd();
    chk("R9 adc value kept", int'(rd_data), 12'h321);

    phase = "R10 push and pop together";
    adc_push(1); adc_push(2);
    adc_valid = 1; adc_data = 3; cpu_rd_en = 1; step();
    cpu_wr_en = 1; cpu_wr_data = 4; cpu_rd_en = 1; step();
    chk("R10 no overflow", int'(overflow), 0);
    chk("R10 no underflow", int'(underflow), 0);
    do_flush();

    phase = "R1 R2 R3 R4 R5 random traffic";
    for (int n = 0; n < 4000; n++) begin
      adc_valid   = ($urandom_range(0, 99) < 40);
      adc_data    = DW'($urandom);
      cpu_wr_en   = ($urandom_range(0, 99) < 15);
      cpu_wr_data = DW'($urandom);
      cpu_rd_en   = ($urandom_range(0, 99) < 45);
      flush       = ($urandom_range(0, 99) < 3);
      step();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule